// File: doc/BRIEF.md
# Indirect Register Access Port

This block is a byte-wide host port. A single control address gives the host access to a bank of internal registers. No register has a bus address of its own. The host first writes a register number, which is the pointer. The next access at the same address is the data transfer: a write stores the byte into the selected register, or a read returns that register's contents. After the data access the port expects a pointer again. A one-bit phase flag tracks whether the next write is a pointer or data.

The register bank is a flat array of 64 bytes. One bit in one register is a reset-hold control. When that bit is written as 1, the port clears the whole bank and holds itself in reset. It leaves that state only when a later write carries a 0 in that bit position. Because of this, the fixed access sequence read, write 0, read, write 0, write 1, write 0 brings the port back to its initial state from any phase. A host can use this sequence at start-up, when the phase of the port is not known.

Each access is one clock cycle with `sel` high. `wr` selects a write (1) or a read (0).

Top module: `ind_reg_port`

## Requirements
- R1: After `rst_n` is released, `rdata` is 0x00, `in_reset` is 0, every register holds 0x00, and the next write is taken as a pointer.
- R2: A write in pointer phase loads the pointer. The following write stores its byte into the pointed register and returns the port to pointer phase.
- R3: A read in data phase returns the pointed register on `rdata`, valid from the clock edge that samples the read. The read returns the port to pointer phase.
- R4: Only the low 6 bits of a pointer byte select the register. Bits 7:6 are ignored, so a pointer of 0x45 selects register 5.
- R5: A read in pointer phase returns 0x00 and leaves the port in pointer phase. The next write is still a pointer.
- R6: After any completed data access, the next write is taken as a pointer.
- R7: Writing a data byte with bit 0 set into register 0 clears every register and raises `in_reset` from the next edge. While `in_reset` is high, reads return 0x00, and writes with bit 0 set keep the hold.
- R8: While `in_reset` is high, a write with bit 0 clear lowers `in_reset`. The port is then in pointer phase with all registers at 0x00.
- R9: The sequence read, write 0x00, read, write 0x00, write 0x01, write 0x00 leaves the port in its initial state (as in R1). This holds whether it starts in pointer phase or in data phase.
- R10: Cycles with `sel` low change neither `rdata`, `in_reset`, the phase nor the pointer, whatever `wr` and `wdata` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Access strobe, one access per cycle when high |
| wr | input | 1 | 1 = write, 0 = read |
| wdata | input | 8 | Write byte (pointer or data) |
| rdata | output | 8 | Read byte, registered |
| in_reset | output | 1 | High while the reset-hold bit is set |

## Verification
Every result is due one edge after the stimulus. For a read, `rdata` takes its value at the clock edge that samples the access. For the write that sets or clears the hold bit, `in_reset` changes at that same edge. A stored byte becomes visible to any read that is sampled at a later edge. The bench drives each access on a falling edge and compares on the next falling edge, which falls between that sampling edge and the next one. The phase of the port is observed only through its effect at the ports: a pointer write, then a read, must return the expected register.

// File: rtl/ind_reg_port.sv
module ind_reg_port #(
  parameter int DW      = 8,
  parameter int AW      = 6,
  parameter int RST_REG = 0,
  parameter int RST_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          in_reset
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] ptr;
  logic          data_phase;

  assign in_reset = mem[RST_REG][RST_BIT];

  wire rd_acc  = sel && !wr;
  wire hold_wr = sel && wr && in_reset;
  wire ptr_wr  = sel && wr && !in_reset && !data_phase;
  wire dat_wr  = sel && wr && !in_reset && data_phase;
  wire arm     = dat_wr && (ptr == AW'(RST_REG)) && wdata[RST_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      ptr        <= '0;
      data_phase <= 1'b0;
    end else if (arm) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      mem[RST_REG][RST_BIT] <= 1'b1;
      ptr        <= '0;
      data_phase <= 1'b0;
    end else if (hold_wr) begin
      mem[RST_REG][RST_BIT] <= wdata[RST_BIT];
      data_phase <= 1'b0;
    end else if (ptr_wr) begin
      ptr        <= wdata[AW-1:0];
      data_phase <= 1'b1;
    end else if (dat_wr) begin
      mem[ptr]   <= wdata;
      data_phase <= 1'b0;
    end else if (rd_acc) begin
      data_phase <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata <= '0;
    else if (rd_acc)
      rdata <= (data_phase && !in_reset) ? mem[ptr] : '0;
  end
endmodule

module ind_reg_port_chk #(
  parameter int DW      = 8,
  parameter int AW      = 6,
  parameter int RST_BIT = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel,
  input logic          wr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          in_reset,
  input logic          data_phase,
  input logic [AW-1:0] ptr
);
  assert_ptr_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel && wr && !data_phase && !in_reset |=> data_phase && ptr == $past(wdata[AW-1:0]));
  assert_idle_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel && !wr && !data_phase |=> !data_phase && rdata == '0);
  assert_back_to_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sel && data_phase |=> !data_phase);
  assert_hold_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel && !wr && in_reset |=> rdata == '0);
  assert_hold_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_reset |-> !data_phase);
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel && wr && in_reset && !wdata[RST_BIT] |=> !in_reset);
  assert_no_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(rdata) && $stable(in_reset) && $stable(data_phase) && $stable(ptr));
endmodule

bind ind_reg_port ind_reg_port_chk #(.DW(DW), .AW(AW), .RST_BIT(RST_BIT)) u_chk (.*);

// File: tb/sim_ind_reg_port.sv
module sim_ind_reg_port;
  logic clk = 0, rst_n = 0, sel = 0, wr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic in_reset;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  ind_reg_port u0 (.clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr),
                   .wdata(wdata), .rdata(rdata), .in_reset(in_reset));

  // kind: 0 idle, 1 write, 2 read and check rdata
  localparam logic [17:0] VEC [16] = '{
    {2'd1, 8'h05, 8'h00}, {2'd1, 8'hA5, 8'h00}, {2'd1, 8'h45, 8'h00}, {2'd2, 8'h00, 8'hA5},
    {2'd1, 8'h3F, 8'h00}, {2'd1, 8'h5A, 8'h00}, {2'd1, 8'h3F, 8'h00}, {2'd2, 8'h00, 8'h5A},
    {2'd2, 8'h00, 8'h00}, {2'd1, 8'h07, 8'h00}, {2'd1, 8'h11, 8'h00}, {2'd1, 8'h07, 8'h00},
    {2'd2, 8'h00, 8'h11}, {2'd0, 8'hFF, 8'h00}, {2'd1, 8'h05, 8'h00}, {2'd2, 8'h00, 8'hA5}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [7:0] d);
    sel = 1; wr = w; wdata = d;
    @(negedge clk);
    sel = 0; wr = 0; wdata = 8'h00;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] exp);
    acc(1'b0, 8'h00);
    chk(req, rdata, exp);
  endtask

  task automatic recover();
    acc(0, 0); acc(1, 0); acc(0, 0); acc(1, 0); acc(1, 1); acc(1, 0);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 in_reset", {7'd0, in_reset}, 8'h00);
    acc(1, 8'h05); rd_chk("R1 reg clear", 8'h00);

    for (int i = 0; i < 16; i++) begin
      case (VEC[i][17:16])
        2'd1: acc(1'b1, VEC[i][15:8]);
        2'd2: rd_chk("R2 R3 R4 R5 R6 vector", VEC[i][7:0]);
        default: @(negedge clk);
      endcase
    end

    // R7 enter hold via register 0
    acc(1, 8'h00); acc(1, 8'h81);
    chk("R7 in_reset set", {7'd0, in_reset}, 8'h01);
    rd_chk("R7 read in hold", 8'h00);
    acc(1, 8'h03);
    chk("R7 hold kept", {7'd0, in_reset}, 8'h01);
    // R8 release
    acc(1, 8'h02);
    chk("R8 in_reset clear", {7'd0, in_reset}, 8'h00);
    acc(1, 8'h05); rd_chk("R8 regs cleared", 8'h00);
    acc(1, 8'h06); acc(1, 8'h77); acc(1, 8'h06); rd_chk("R8 pointer phase", 8'h77);

    // R9 from data phase
    acc(1, 8'h10);
    recover();
    chk("R9 in_reset", {7'd0, in_reset}, 8'h00);
    acc(1, 8'h06); rd_chk("R9 cleared from data phase", 8'h00);
    // R9 from pointer phase
    acc(1, 8'h09); acc(1, 8'h33);
    recover();
    acc(1, 8'h09); rd_chk("R9 cleared from pointer phase", 8'h00);
    acc(1, 8'h09); acc(1, 8'h3C); acc(1, 8'h09); rd_chk("R9 usable after", 8'h3C);

    // R10 idle cycles with noise
    acc(1, 8'h0A); acc(1, 8'h44); acc(1, 8'h0A);
    for (int k = 0; k < 5; k++) begin
      wr = k[0]; wdata = 8'hC3 ^ 8'(k);
      @(negedge clk);
    end
    wr = 0; wdata = 0;
    chk("R10 rdata stable", rdata, 8'h3C);
    chk("R10 in_reset stable", {7'd0, in_reset}, 8'h00);
    rd_chk("R10 phase kept", 8'h44);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule